// File: doc/BRIEF.md
# Per-Core Local Interrupt Router

This block steers the interrupt sources that belong to a four-core cluster onto two lines per core: a normal-priority IRQ and a fast FIQ. Each core brings four timer lines, four mailbox-pending lines and one performance-monitor line. One shared peripheral line is also steered, and it reaches exactly one core at a time. A 32-bit register port sets the routing. Through the same port software reads, for each core, a pending word. This word shows which of that core's sources are active and routed.

Routing state is held in three forms. Timer and mailbox routing sit in a plain read/write word for each core. Performance-monitor routing is one shared word that is changed only through separate write-1-to-set and write-1-to-clear addresses. The shared line is steered by small core-index fields. The IRQ and FIQ outputs are registered, so they follow a change at the inputs or in the configuration one clock later.

Top module: `lirq_router`

## Requirements
- R1: After reset every routing word reads 0, and all eight outputs are low. Writing 0 to a timer routing word (byte address 0x40 + 4*core) afterwards routes none of that core's timers.
- R2: In a timer routing word, bit t (t = 0..3) sends timer t of that core to the core's IRQ, and bit 4+t sends it to the core's FIQ. Timer t of core c is input bit timerIn[4*c+t].
- R3: When both the IRQ and FIQ bit are set for one timer or mailbox source, that source drives only the FIQ.
- R4: Mailbox routing words at 0x50 + 4*core use the same bit layout as the timer words, for mailbox lines mboxIn[4*c+m].
- R5: Writing to 0x10 sets each routing bit whose data bit is 1. Writing to 0x14 clears each routing bit whose data bit is 1. Data bits that are 0 leave the routing unchanged. Both addresses read back the current 8-bit word. Bit c is the IRQ enable for pmuIn[c], and bit 4+c is the FIQ enable. FIQ wins when both are set.
- R6: At 0x0C, bits [1:0] name the core for a shared IRQ and bits [3:2] name the core for a shared FIQ. Bit 4 chooses which of the two is used (0 selects IRQ, 1 selects FIQ). The shared line reaches exactly one core.
- R7: The pending word of core c at 0x60 + 4*c has the routed, active timers at bits 0-3 and the mailboxes at bits 4-7. The shared line is at bit 8, and only in the selected core. The performance monitor is at bit 9. Bits 10 and 11 read 0, and so does every source that is not routed.
- R8: Pending words are read-only. A write to them changes no register and no output.
- R9: The prescaler word at 0x08 and the control word at 0x00 store a written value, for example 0x80000000, and return it on read.
- R10: irqOut and fiqOut change on the first clock edge after the input or configuration change that causes them, and not in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the register port |
| addr | input | 8 | Byte address, word aligned |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for addr (combinational) |
| timerIn | input | 16 | Timer lines, four per core |
| mboxIn | input | 16 | Mailbox pending lines, four per core |
| pmuIn | input | 4 | Performance-monitor line per core |
| sharedIn | input | 1 | Shared peripheral interrupt |
| irqOut | output | 4 | IRQ per core, registered |
| fiqOut | output | 4 | FIQ per core, registered |

## Verification
The hardest case to reach is the performance-monitor routing word, because it can only be changed in increments. The stimulus builds it up with several set writes and then applies a clear write with a zero mask. It reads the word back after each step, so a set or clear that touches the wrong bits shows up in the readback. A second case is moving the shared line between two cores by flipping only the select bit. Both cores' pending words are then read, so that a copy left behind in the first core is caught.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
  localparam int LIRQ_CORES  = 4;
  localparam int LIRQ_SRC_N  = 4;
  localparam int LIRQ_DATA_W = 32;
  localparam int LIRQ_ADDR_W = 8;
  localparam int CORE_IDX_W  = $clog2(LIRQ_CORES);
  localparam int PEND_W      = 2 * LIRQ_SRC_N + 4;

  typedef enum logic [2:0] {
    RD_NONE, RD_CTRL, RD_PRESC, RD_SHARED, RD_PMU, RD_TIMER, RD_MBOX, RD_PEND
  } rdSel_e;

  typedef struct packed {
    logic                  ctrlWr;
    logic                  prescWr;
    logic                  sharedWr;
    logic                  pmuSet;
    logic                  pmuClr;
    logic                  timerWr;
    logic                  mboxWr;
    logic [CORE_IDX_W-1:0] core;
    rdSel_e                rdSel;
  } regStrobe_t;
endpackage

// File: rtl/lirq_decode.sv
module lirq_decode
  import lirq_pkg::*;
#(
  parameter int ADDR_W = LIRQ_ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output regStrobe_t        strb
);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_PRESC  = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_SHARED = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] A_PMUSET = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_PMUCLR = ADDR_W'(8'h14);
  localparam logic [3:0] G_TIMER = 4'h4;
  localparam logic [3:0] G_MBOX  = 4'h5;
  localparam logic [3:0] G_PEND  = 4'h6;

  logic [3:0] grp;
  assign grp = addr[7:4];

  always_comb begin
    strb       = '0;
    strb.rdSel = RD_NONE;
    strb.core  = addr[2 +: CORE_IDX_W];
    if (addr == A_CTRL) begin
      strb.rdSel  = RD_CTRL;
      strb.ctrlWr = wrEn;
    end else if (addr == A_PRESC) begin
      strb.rdSel   = RD_PRESC;
      strb.prescWr = wrEn;
    end else if (addr == A_SHARED) begin
      strb.rdSel    = RD_SHARED;
      strb.sharedWr = wrEn;
    end else if (addr == A_PMUSET) begin
      strb.rdSel  = RD_PMU;
      strb.pmuSet = wrEn;
    end else if (addr == A_PMUCLR) begin
      strb.rdSel  = RD_PMU;
      strb.pmuClr = wrEn;
    end else if (grp == G_TIMER) begin
      strb.rdSel   = RD_TIMER;
      strb.timerWr = wrEn;
    end else if (grp == G_MBOX) begin
      strb.rdSel  = RD_MBOX;
      strb.mboxWr = wrEn;
    end else if (grp == G_PEND) begin
      strb.rdSel = RD_PEND;
    end
  end

  // R8: at most one register is written per access
  p_one_strobe_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.ctrlWr, strb.prescWr, strb.sharedWr, strb.pmuSet,
              strb.pmuClr, strb.timerWr, strb.mboxWr}));

  // R8: a write aimed at a pending word raises no strobe
  p_pend_wr_ignored_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && grp == G_PEND) |->
      !(strb.ctrlWr || strb.prescWr || strb.sharedWr || strb.pmuSet ||
        strb.pmuClr || strb.timerWr || strb.mboxWr));
endmodule

// File: rtl/lirq_route.sv
module lirq_route
  import lirq_pkg::*;
#(
  parameter int NUM_CORES = LIRQ_CORES,
  parameter int SRC_N     = LIRQ_SRC_N,
  parameter int DATA_W    = LIRQ_DATA_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  regStrobe_t                 strb,
  input  logic [DATA_W-1:0]          wrData,
  input  logic [NUM_CORES*SRC_N-1:0] timerIn,
  input  logic [NUM_CORES*SRC_N-1:0] mboxIn,
  input  logic [NUM_CORES-1:0]       pmuIn,
  input  logic                       sharedIn,
  output logic [DATA_W-1:0]          rdData,
  output logic [NUM_CORES-1:0]       irqOut,
  output logic [NUM_CORES-1:0]       fiqOut
);
  localparam int CFG_W    = 2 * SRC_N;
  localparam int PMU_W    = 2 * NUM_CORES;
  localparam int SHR_W    = 2 * CORE_IDX_W + 1;
  localparam int SHR_FSEL = 2 * CORE_IDX_W;
  localparam int PB_SHR   = 2 * SRC_N;
  localparam int PB_PMU   = 2 * SRC_N + 1;

  logic [DATA_W-1:0]    ctrlReg, prescReg;
  logic [SHR_W-1:0]     sharedReg;
  logic [PMU_W-1:0]     pmuReg;
  logic [CFG_W-1:0]     timerCfg [NUM_CORES];
  logic [CFG_W-1:0]     mboxCfg  [NUM_CORES];
  logic [PEND_W-1:0]    pend     [NUM_CORES];
  logic [NUM_CORES-1:0] irqNext, fiqNext, sharedHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      prescReg  <= '0;
      sharedReg <= '0;
      pmuReg    <= '0;
    end else begin
      if (strb.ctrlWr)   ctrlReg   <= wrData;
      if (strb.prescWr)  prescReg  <= wrData;
      if (strb.sharedWr) sharedReg <= wrData[SHR_W-1:0];
      if (strb.pmuSet)   pmuReg    <= pmuReg | wrData[PMU_W-1:0];
      else if (strb.pmuClr) pmuReg <= pmuReg & ~wrData[PMU_W-1:0];
    end
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic [SRC_N-1:0] tAct, mAct, tIrq, tFiq, mIrq, mFiq;
    logic             pIrq, pFiq, sIrq, sFiq;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        timerCfg[c] <= '0;
        mboxCfg[c]  <= '0;
      end else begin
        if (strb.timerWr && strb.core == CORE_IDX_W'(c)) timerCfg[c] <= wrData[CFG_W-1:0];
        if (strb.mboxWr  && strb.core == CORE_IDX_W'(c)) mboxCfg[c]  <= wrData[CFG_W-1:0];
      end
    end

    assign tAct = timerIn[c*SRC_N +: SRC_N];
    assign mAct = mboxIn[c*SRC_N +: SRC_N];
    assign tFiq = tAct & timerCfg[c][CFG_W-1:SRC_N];
    assign tIrq = tAct & timerCfg[c][SRC_N-1:0] & ~timerCfg[c][CFG_W-1:SRC_N];
    assign mFiq = mAct & mboxCfg[c][CFG_W-1:SRC_N];
    assign mIrq = mAct & mboxCfg[c][SRC_N-1:0] & ~mboxCfg[c][CFG_W-1:SRC_N];
    assign pFiq = pmuIn[c] & pmuReg[NUM_CORES + c];
    assign pIrq = pmuIn[c] & pmuReg[c] & ~pmuReg[NUM_CORES + c];
    assign sFiq = sharedIn & sharedReg[SHR_FSEL] &
                  (sharedReg[2*CORE_IDX_W-1:CORE_IDX_W] == CORE_IDX_W'(c));
    assign sIrq = sharedIn & ~sharedReg[SHR_FSEL] &
                  (sharedReg[CORE_IDX_W-1:0] == CORE_IDX_W'(c));
    assign sharedHit[c] = sIrq | sFiq;

    always_comb begin
      pend[c]                  = '0;
      pend[c][SRC_N-1:0]       = tIrq | tFiq;
      pend[c][CFG_W-1:SRC_N]   = mIrq | mFiq;
      pend[c][PB_SHR]          = sharedHit[c];
      pend[c][PB_PMU]          = pIrq | pFiq;
    end

    assign irqNext[c] = |tIrq | |mIrq | pIrq | sIrq;
    assign fiqNext[c] = |tFiq | |mFiq | pFiq | sFiq;

    // R3: a timer with both enables set lands on the FIQ one edge later
    p_fiq_wins_r3: assert property (@(posedge clk) disable iff (!rstN)
      ((tAct & timerCfg[c][SRC_N-1:0] & timerCfg[c][CFG_W-1:SRC_N]) != '0) |=> fiqOut[c]);

    // R2: a timer word write is stored as written
    p_cfg_write_r2: assert property (@(posedge clk) disable iff (!rstN)
      (strb.timerWr && strb.core == CORE_IDX_W'(c)) |=> timerCfg[c] == $past(wrData[CFG_W-1:0]));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqOut <= '0;
      fiqOut <= '0;
    end else begin
      irqOut <= irqNext;
      fiqOut <= fiqNext;
    end
  end

  always_comb begin
    unique case (strb.rdSel)
      RD_CTRL:   rdData = ctrlReg;
      RD_PRESC:  rdData = prescReg;
      RD_SHARED: rdData = DATA_W'(sharedReg);
      RD_PMU:    rdData = DATA_W'(pmuReg);
      RD_TIMER:  rdData = DATA_W'(timerCfg[strb.core]);
      RD_MBOX:   rdData = DATA_W'(mboxCfg[strb.core]);
      RD_PEND:   rdData = DATA_W'(pend[strb.core]);
      default:   rdData = '0;
    endcase
  end

  // R5: a set write leaves every written 1 bit set
  p_pmu_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.pmuSet |=> (pmuReg & $past(wrData[PMU_W-1:0])) == $past(wrData[PMU_W-1:0]));

  // R5: a clear write leaves every written 1 bit clear
  p_pmu_clr_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.pmuClr |=> (pmuReg & $past(wrData[PMU_W-1:0])) == '0);

  // R5: without a set or clear write the routing word holds
  p_pmu_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.pmuSet || strb.pmuClr) |=> $stable(pmuReg));

  // R6: the shared line reaches at most one core
  p_shared_one_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(sharedHit));
endmodule

// File: rtl/lirq_router.sv
module lirq_router
  import lirq_pkg::*;
#(
  parameter int NUM_CORES = LIRQ_CORES,
  parameter int SRC_N     = LIRQ_SRC_N,
  parameter int DATA_W    = LIRQ_DATA_W,
  parameter int ADDR_W    = LIRQ_ADDR_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wrData,
  output logic [DATA_W-1:0]          rdData,
  input  logic [NUM_CORES*SRC_N-1:0] timerIn,
  input  logic [NUM_CORES*SRC_N-1:0] mboxIn,
  input  logic [NUM_CORES-1:0]       pmuIn,
  input  logic                       sharedIn,
  output logic [NUM_CORES-1:0]       irqOut,
  output logic [NUM_CORES-1:0]       fiqOut
);
  regStrobe_t strb;

  lirq_decode #(.ADDR_W(ADDR_W)) u_decode (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .strb(strb)
  );

  lirq_route #(.NUM_CORES(NUM_CORES), .SRC_N(SRC_N), .DATA_W(DATA_W)) u_route (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .timerIn(timerIn), .mboxIn(mboxIn), .pmuIn(pmuIn), .sharedIn(sharedIn),
    .rdData(rdData), .irqOut(irqOut), .fiqOut(fiqOut)
  );
endmodule

// File: tb/lirq_router_bench.sv
module lirq_router_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [15:0] timerIn = '0;
  logic [15:0] mboxIn = '0;
  logic [3:0]  pmuIn = '0;
  logic        sharedIn = 1'b0;
  logic [3:0]  irqOut, fiqOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    bit          isOut;
    logic [31:0] exp;
    string       tag;
  } expItem_t;
  expItem_t sbq[$];

  always #4 clk = ~clk;

  lirq_router u_lirq_router (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .timerIn(timerIn), .mboxIn(mboxIn), .pmuIn(pmuIn),
    .sharedIn(sharedIn), .irqOut(irqOut), .fiqOut(fiqOut)
  );

  // monitor: pops expected items and compares mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      while (sbq.size() > 0) begin
        expItem_t it;
        logic [31:0] act;
        it = sbq.pop_front();
        act = it.isOut ? {24'h0, fiqOut, irqOut} : rdData;
        checks++;
        if (act !== it.exp) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    tick();
    wrEn = 1'b1; addr = a; wrData = d;
    tick();
    wrEn = 1'b0;
  endtask

  task automatic expRd(input logic [7:0] a, input logic [31:0] e, input string tag);
    tick();
    addr = a;
    sbq.push_back('{1'b0, e, tag});
  endtask

  // expected {fiqOut, irqOut}, checked in the current cycle
  task automatic expOut(input logic [7:0] e, input string tag);
    sbq.push_back('{1'b1, {24'h0, e}, tag});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    // R1 reset state
    expOut(8'h00, "R1 outputs after reset");
    expRd(8'h40, 0, "R1 timer word");
    expRd(8'h54, 0, "R1 mailbox word");
    expRd(8'h10, 0, "R1 pmu word");
    expRd(8'h0C, 0, "R1 shared word");
    expRd(8'h60, 0, "R1 pending");
    // R9 storage words
    wr(8'h08, 32'h8000_0000);
    expRd(8'h08, 32'h8000_0000, "R9 prescaler");
    wr(8'h00, 32'h0000_0003);
    expRd(8'h00, 32'h0000_0003, "R9 control");
    // R2 / R10 timer IRQ
    wr(8'h44, 32'h01);
    tick();
    timerIn[4] = 1'b1;
    expOut(8'h00, "R10 no change before edge");
    tick();
    expOut(8'h02, "R2 irq core1 timer0");
    expRd(8'h64, 32'h001, "R7 pending timer0 core1");
    // R3 FIQ priority
    wr(8'h44, 32'h11);
    tick();
    expOut(8'h20, "R3 fiq wins core1");
    // R2 FIQ-only timer on core3
    timerIn = '0;
    wr(8'h4C, 32'h40);
    timerIn[14] = 1'b1;
    tick();
    expOut(8'h80, "R2 fiq core3 timer2");
    // R7 unrouted source
    timerIn = 16'h0001;
    tick();
    expOut(8'h00, "R7 unrouted no output");
    expRd(8'h60, 0, "R7 unrouted pending");
    // R1 zero write routes nothing
    wr(8'h4C, 32'h0);
    timerIn = 16'h4000;
    tick();
    expOut(8'h00, "R1 zeroed timer word");
    expRd(8'h4C, 0, "R1 timer word zero readback");
    expRd(8'h6C, 0, "R1 pending core3 zero");
    // R4 mailbox routing
    timerIn = '0;
    wr(8'h58, 32'h02);
    mboxIn[9] = 1'b1;
    tick();
    expOut(8'h04, "R4 irq core2 mbox1");
    expRd(8'h68, 32'h020, "R4 pending mbox1 core2");
    wr(8'h58, 32'h22);
    tick();
    expOut(8'h40, "R3 mailbox fiq wins core2");
    mboxIn = '0;
    // R5 set/clear routing
    wr(8'h10, 32'h21);
    expRd(8'h10, 32'h21, "R5 first set");
    wr(8'h10, 32'h02);
    expRd(8'h10, 32'h23, "R5 set keeps earlier bits");
    wr(8'h14, 32'h01);
    expRd(8'h10, 32'h22, "R5 clear one bit");
    wr(8'h14, 32'h00);
    expRd(8'h14, 32'h22, "R5 zero clear no effect");
    pmuIn = 4'b0010;
    tick();
    expOut(8'h20, "R5 pmu fiq wins core1");
    expRd(8'h64, 32'h200, "R7 pending pmu core1");
    wr(8'h14, 32'h20);
    tick();
    expOut(8'h02, "R5 pmu irq core1 after clear");
    pmuIn = '0;
    // R6 shared routing
    wr(8'h0C, 32'h06);
    sharedIn = 1'b1;
    tick();
    expOut(8'h04, "R6 shared irq core2");
    expRd(8'h68, 32'h100, "R6 pending shared core2");
    expRd(8'h64, 32'h000, "R6 core1 not pending");
    wr(8'h0C, 32'h16);
    tick();
    expOut(8'h20, "R6 shared fiq core1");
    expRd(8'h64, 32'h100, "R6 pending shared core1");
    expRd(8'h68, 32'h000, "R6 core2 no longer pending");
    sharedIn = 1'b0;
    // R8 pending read-only
    wr(8'h64, 32'h0000_0FFF);
    expRd(8'h64, 32'h0, "R8 pending unchanged");
    expRd(8'h44, 32'h11, "R8 timer word untouched");
    expRd(8'h10, 32'h02, "R8 pmu word untouched");
    expRd(8'h0C, 32'h16, "R8 shared word untouched");
    expOut(8'h00, "R8 outputs quiet");
    // R7 full pending layout on core0
    wr(8'h40, 32'h0F);
    wr(8'h50, 32'h0F);
    wr(8'h10, 32'h01);
    wr(8'h0C, 32'h00);
    timerIn = 16'h000F; mboxIn = 16'h000F; pmuIn = 4'b0001; sharedIn = 1'b1;
    tick();
    expRd(8'h60, 32'h3FF, "R7 all sources core0, bits 10-11 zero");
    expOut(8'h01, "R7 irq core0 only");
    expRd(8'h64, 32'h0, "R7 core1 idle");
    tick();
    tick();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule